// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides when a CAN node that has gone bus-off may rejoin the bus. A pulse on the entry input puts it in the bus-off state. From then on it watches the bus one sampled bit at a time, counting runs of consecutive recessive bits. Once enough complete runs have been seen, it emits a one-cycle rejoin pulse and drops its bus-off flag.

A user inhibit input can hold the node off the bus. The controller captures that input when bus-off begins. If the user releases the inhibit before the run count completes, recovery happens at the usual point. If the release comes after the run count has completed, the node first resynchronises on one further run of recessive bits. Raising the inhibit during a bus-off that began without it has no effect until the next bus-off.

Top module: `busoff_recovery_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `off_flag` and `rejoin_pulse` are both 0.
- R2: An `enter_pulse` sampled while `off_flag` is 0 sets `off_flag` on the next cycle. `off_flag` never rises without that pulse.
- R3: If `hold_req` was 0 at entry, a `rejoin_pulse` is raised on the cycle after the strobe that completes the `SEQ_TARGET`-th run of `RUN_LEN` consecutive recessive bits (`bit_level` = 1). `off_flag` falls in that same cycle.
- R4: A dominant bit (`bit_strobe` = 1 with `bit_level` = 0) restarts the current recessive run from zero. Runs already completed are kept.
- R5: `rejoin_pulse` is high for exactly one cycle per recovery.
- R6: If `hold_req` was 1 at entry and stays 1, the node stays bus-off no matter how many recessive runs are seen.
- R7: If `hold_req` was 1 at entry and falls to 0 no later than the strobe that completes the last run, rejoin happens at the same bit as under R3.
- R8: If `hold_req` falls only after the run count has completed, the strobe in that release cycle is not counted. Rejoin then follows the strobe that completes one further run of `RUN_LEN` consecutive recessive bits. A dominant bit restarts that run.
- R9: Raising `hold_req` during a bus-off that began with `hold_req` at 0 does not delay recovery.
- R10: Bits strobed while the node is not bus-off are not counted. Both counters start from zero at each entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enter_pulse | input | 1 | One-cycle request to enter bus-off |
| bit_strobe | input | 1 | High for one cycle per received bit |
| bit_level | input | 1 | Sampled bus level: 1 recessive, 0 dominant |
| hold_req | input | 1 | User request to inhibit automatic recovery |
| off_flag | output | 1 | Node is in bus-off |
| rejoin_pulse | output | 1 | One-cycle pulse when the node rejoins |

## Verification
The bench builds the controller with `RUN_LEN` = 3 and `SEQ_TARGET` = 4. With these values a whole recovery takes twelve recessive bits, so every path fits in a few dozen strobes. Those paths are the held state, a release before and after completion, a release on the completing bit, and a dominant bit inside the resync run. Each path's rejoin bit index is compared against a value worked out by hand. The default values, 11 and 128, use the same comparison logic with wider counters.

// File: rtl/busoff_recovery_pkg.sv
// Shared types for the bus-off recovery controller.
package busoff_recovery_pkg;

    // Recovery phases of the controller.
    typedef enum logic [1:0] {
        PH_ON     = 2'd0,  // participating on the bus
        PH_COUNT  = 2'd1,  // bus-off, counting recessive runs
        PH_HELD   = 2'd2,  // run count done, user inhibit still active
        PH_RESYNC = 2'd3   // released late, waiting for one more run
    } phase_t;

endpackage

// File: rtl/recessive_run_counter.sv
// Counts consecutive recessive bits and flags each completed run.
// Assumes RUN_LEN >= 2. A dominant bit restarts the run. 'clear' holds the
// count at zero. run_done is combinational and is valid in the cycle of the
// strobe that completes a run.
module recessive_run_counter #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic level,
    output logic run_done
);
    localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    logic [RUN_W-1:0] run_cnt;

    // Advance on recessive, restart on dominant or at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_cnt <= '0;
        end else if (count_en) begin
            if (!level || run_cnt == RUN_LAST) begin
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign run_done = count_en && level && (run_cnt == RUN_LAST);

endmodule

// File: rtl/run_sequence_counter.sv
// Counts completed recessive runs up to SEQ_TARGET.
// Assumes SEQ_TARGET >= 2. target_hit is combinational and is valid in the
// cycle that brings the count to the target. The count returns to zero then.
module run_sequence_counter #(
    parameter int SEQ_TARGET = 128,
    parameter int SEQ_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic             target_hit,
    output logic [SEQ_W-1:0] seq_count
);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_TARGET - 1);

    // Increment per completed run and wrap to zero on reaching the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seq_count <= '0;
        end else if (inc) begin
            seq_count <= (seq_count == SEQ_LAST) ? '0 : seq_count + 1'b1;
        end
    end

    assign target_hit = inc && (seq_count == SEQ_LAST);

endmodule

// File: rtl/busoff_recovery_ctrl.sv
// Bus-off recovery controller, top level.
// Enters bus-off on enter_pulse and captures hold_req as the effective
// inhibit. It rejoins after SEQ_TARGET runs of RUN_LEN recessive bits. If the
// inhibit is released only after that point, it waits for one more run first.
// Assumes that bit_strobe is a one-cycle pulse per bus bit.
module busoff_recovery_ctrl
    import busoff_recovery_pkg::*;
#(
    parameter int RUN_LEN    = 11,
    parameter int SEQ_TARGET = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_pulse,
    input  logic bit_strobe,
    input  logic bit_level,
    input  logic hold_req,
    output logic off_flag,
    output logic rejoin_pulse
);
    localparam int SEQ_W = $clog2(SEQ_TARGET + 1);

    phase_t           phase;
    logic             inhibit_q;
    logic             inhibit_eff;
    logic             run_clear;
    logic             run_count_en;
    logic             run_done;
    logic             seq_clear;
    logic             seq_inc;
    logic             target_hit;
    logic [SEQ_W-1:0] seq_count;

    // Count bits only while counting runs or resynchronising.
    always_comb begin
        run_clear    = (phase == PH_ON) || (phase == PH_HELD);
        run_count_en = bit_strobe && ((phase == PH_COUNT) || (phase == PH_RESYNC));
        seq_clear    = (phase == PH_ON);
        seq_inc      = run_done && (phase == PH_COUNT);
        inhibit_eff  = inhibit_q && hold_req;
    end

    recessive_run_counter #(
        .RUN_LEN (RUN_LEN)
    ) run_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (run_clear),
        .count_en (run_count_en),
        .level    (bit_level),
        .run_done (run_done)
    );

    run_sequence_counter #(
        .SEQ_TARGET (SEQ_TARGET),
        .SEQ_W      (SEQ_W)
    ) seq_ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (seq_clear),
        .inc        (seq_inc),
        .target_hit (target_hit),
        .seq_count  (seq_count)
    );

    // Recovery phase sequencing, inhibit capture and the rejoin pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_ON;
            inhibit_q    <= 1'b0;
            off_flag     <= 1'b0;
            rejoin_pulse <= 1'b0;
        end else begin
            rejoin_pulse <= 1'b0;
            unique case (phase)
                PH_ON: begin
                    if (enter_pulse) begin
                        phase     <= PH_COUNT;
                        off_flag  <= 1'b1;
                        inhibit_q <= hold_req;
                    end
                end
                PH_COUNT: begin
                    inhibit_q <= inhibit_eff;
                    if (target_hit) begin
                        if (inhibit_eff) begin
                            phase <= PH_HELD;
                        end else begin
                            phase        <= PH_ON;
                            off_flag     <= 1'b0;
                            rejoin_pulse <= 1'b1;
                        end
                    end
                end
                PH_HELD: begin
                    if (!hold_req) begin
                        phase     <= PH_RESYNC;
                        inhibit_q <= 1'b0;
                    end
                end
                PH_RESYNC: begin
                    if (run_done) begin
                        phase        <= PH_ON;
                        off_flag     <= 1'b0;
                        rejoin_pulse <= 1'b1;
                    end
                end
                default: phase <= PH_ON;
            endcase
        end
    end

endmodule

// File: rtl/busoff_recovery_chk.sv
// Property checker for busoff_recovery_ctrl, attached with bind.
// Observes the top ports, the captured inhibit and the run-sequence count.
module busoff_recovery_chk #(
    parameter int SEQ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enter_pulse,
    input logic             off_flag,
    input logic             rejoin_pulse,
    input logic             inhibit_q,
    input logic [SEQ_W-1:0] seq_count
);
    // R2
    entry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse && !off_flag |=> off_flag);

    // R2
    flag_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !off_flag && !enter_pulse |=> !off_flag);

    // R3
    rejoin_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rejoin_pulse |-> !off_flag && $past(off_flag));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rejoin_pulse |=> !rejoin_pulse);

    // R9
    no_inhibit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_flag && !inhibit_q |=> !inhibit_q);

    // R10
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !off_flag |-> seq_count == '0);

endmodule

bind busoff_recovery_ctrl busoff_recovery_chk #(
    .SEQ_W (SEQ_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_pulse  (enter_pulse),
    .off_flag     (off_flag),
    .rejoin_pulse (rejoin_pulse),
    .inhibit_q    (inhibit_q),
    .seq_count    (seq_count)
);

// File: tb/busoff_recovery_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for busoff_recovery_ctrl with RUN_LEN=3 and SEQ_TARGET=4.
module busoff_recovery_ctrl_tb_top;
    localparam int RL = 3;
    localparam int ST = 4;
    localparam logic [7:0] NONE = 8'd255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_pulse = 1'b0;
    logic bit_strobe = 1'b0;
    logic bit_level = 1'b1;
    logic hold_req = 1'b0;
    logic off_flag;
    logic rejoin_pulse;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    busoff_recovery_ctrl #(.RUN_LEN(RL), .SEQ_TARGET(ST)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_pulse  (enter_pulse),
        .bit_strobe   (bit_strobe),
        .bit_level    (bit_level),
        .hold_req     (hold_req),
        .off_flag     (off_flag),
        .rejoin_pulse (rejoin_pulse)
    );

    // One recovery scenario: inhibit at entry, bit index that sets it,
    // bit index that clears it, index of a dominant bit, bits fed, and the
    // index after which rejoin is expected (NONE for no rejoin).
    typedef struct packed {
        logic       hold0;
        logic [7:0] set_i;
        logic [7:0] rel_i;
        logic [7:0] dom_i;
        logic [7:0] nbits;
        logic [7:0] exp_i;
    } scen_t;

    localparam int NSC = 8;
    localparam scen_t SCEN [NSC] = '{
        '{1'b0, NONE,  NONE,  NONE,  8'd16, 8'd11},  // R3 plain recovery
        '{1'b0, NONE,  NONE,  8'd4,  8'd18, 8'd13},  // R4 dominant mid-run
        '{1'b0, NONE,  NONE,  8'd2,  8'd18, 8'd14},  // R4 dominant at run start
        '{1'b1, NONE,  NONE,  NONE,  8'd24, NONE },  // R6 held forever
        '{1'b1, NONE,  8'd5,  NONE,  8'd16, 8'd11},  // R7 early release
        '{1'b1, NONE,  8'd11, NONE,  8'd16, 8'd11},  // R7 release on last bit
        '{1'b1, NONE,  8'd14, 8'd16, 8'd24, 8'd19},  // R8 late release, dominant
        '{1'b0, 8'd3,  NONE,  NONE,  8'd16, 8'd11}   // R9 set during bus-off
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        enter_pulse = 1'b0;
        bit_strobe = 1'b0;
        hold_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(off_flag == 1'b0 && rejoin_pulse == 1'b0, "R1 in reset", off_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(off_flag == 1'b0 && rejoin_pulse == 1'b0, "R1 after reset", off_flag, 0);
    endtask

    task automatic enter(input logic h);
        hold_req = h;
        enter_pulse = 1'b1;
        @(negedge clk);
        enter_pulse = 1'b0;
        chk(off_flag == 1'b1, "R2 entry sets flag", off_flag, 1);
    endtask

    // Feed one bit, then sample the outputs one cycle later.
    task automatic feed(input logic lvl, output logic rj, output logic off);
        bit_level = lvl;
        bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
        rj = rejoin_pulse;
        off = off_flag;
    endtask

    initial begin
        logic rj;
        logic off;
        do_reset();
        @(negedge clk);
        chk(off_flag == 1'b0, "R2 no entry keeps flag low", off_flag, 0);

        for (int s = 0; s < NSC; s++) begin
            int seen;
            int pulses;
            do_reset();
            enter(SCEN[s].hold0);
            seen = 255;
            pulses = 0;
            for (int i = 0; i < int'(SCEN[s].nbits); i++) begin
                if (i == int'(SCEN[s].set_i)) hold_req = 1'b1;
                if (i == int'(SCEN[s].rel_i)) hold_req = 1'b0;
                feed(i != int'(SCEN[s].dom_i), rj, off);
                if (rj) begin
                    pulses++;
                    seen = i;
                    chk(off == 1'b0, "R3 flag falls with rejoin", off, 0);
                end
            end
            @(negedge clk);
            if (rejoin_pulse) pulses++;
            chk(seen == int'(SCEN[s].exp_i), "R3/R4/R6/R7/R8/R9 rejoin bit index",
                seen, int'(SCEN[s].exp_i));
            chk(pulses == ((SCEN[s].exp_i == NONE) ? 0 : 1), "R5 one pulse per recovery",
                pulses, (SCEN[s].exp_i == NONE) ? 0 : 1);
            chk(off_flag == (SCEN[s].exp_i == NONE), "R6 final flag state",
                off_flag, int'(SCEN[s].exp_i == NONE));
        end

        // R10: recessive bits while on the bus are not counted.
        do_reset();
        for (int i = 0; i < 10; i++) begin
            feed(1'b1, rj, off);
            chk(rj == 1'b0 && off == 1'b0, "R10 no action while on bus", rj, 0);
        end
        enter(1'b0);
        begin
            int seen;
            seen = 255;
            for (int i = 0; i < 14; i++) begin
                feed(1'b1, rj, off);
                if (rj && seen == 255) seen = i;
            end
            chk(seen == RL * ST - 1, "R10 full count after entry", seen, RL * ST - 1);
        end

        // R5: the pulse drops in the cycle after it rises, with no strobes.
        do_reset();
        enter(1'b0);
        for (int i = 0; i < RL * ST; i++) feed(1'b1, rj, off);
        chk(rj == 1'b1, "R5 pulse present", rj, 1);
        @(negedge clk);
        chk(rejoin_pulse == 1'b0, "R5 pulse one cycle", rejoin_pulse, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule